// File: doc/BRIEF.md
# Line-Merging Write Buffer

This block sits between a core's store port and the memory side of a cache hierarchy. Word-sized writes arrive with a word address and data under a valid/ready handshake. Each write is filed under its cache line, which is four 32-bit words. When a write targets a line that already waits in the buffer, the write is folded into that waiting line and takes no new slot. The memory side receives one write-back per line. Each write-back carries every word gathered so far, plus a four-bit mask that marks which words hold data.

Because a later write can join an older line, the buffer saves write-back bandwidth. As a result, stores to different lines can reach memory in a different order from the order they were issued. This gives partial-store-order behaviour. The memory side always drains the oldest line that is still held. A fence input stops intake until everything already buffered has left, so no reordering crosses the fence.

Top module: `line_merge_wbuf`

## Requirements
- R1: After reset the buffer holds no lines: `wb_valid` is 0 and, with `fence` low, `wr_ready` is 1.
- R2: The line address is `wr_addr[15:2]` and the word within the line is `wr_addr[1:0]`. An accepted write whose line matches a held line that is not leaving in that cycle is merged into it. It sets mask bit `wr_addr[1:0]` and takes no new slot.
- R3: A merge into a word whose mask bit is already set replaces that word with the newer data.
- R4: While any line is held, `wb_valid` is 1 and the outputs show the oldest held line: `wb_line` is its line address, word k appears at `wb_data[32k+31:32k]` and `wb_mask[k]` marks it. These stay on the oldest line until `wb_ready` is seen high.
- R5: Writes X, Y, Z issued in that order, with X and Z in one line and Y in another, leave as one write-back carrying X and Z, followed by a write-back carrying Y.
- R6: At most 4 lines are held. With all 4 occupied, a write to a line not held is refused (`wr_ready` is 0), while a write to a held line is still accepted.
- R7: A write to the oldest line in the same cycle that line is taken by memory does not merge. It opens a new line holding only that word.
- R8: In the cycle `fence` is high `wr_ready` is 0, and it stays 0 until no line is held. All lines written before the fence leave before any line written after it.
- R9: A held line stays open for merging until memory takes it. A merge into the oldest line while `wb_ready` is low shows up on `wb_data`/`wb_mask` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Core write request |
| wr_ready | output | 1 | Buffer accepts the write this cycle |
| wr_addr | input | 16 | Word address; upper 14 bits select the line, lower 2 the word |
| wr_data | input | 32 | Write data |
| fence | input | 1 | Drain everything before accepting more writes |
| wb_valid | output | 1 | A line write-back is offered |
| wb_ready | input | 1 | Memory takes the offered line |
| wb_line | output | 14 | Line address of the write-back |
| wb_data | output | 128 | Four words of line data, word 0 in the low bits |
| wb_mask | output | 4 | Which words of the line carry data |

## Verification
Random stimulus restricted to six lines keeps merges, overwrites and full-buffer stalls frequent. A low memory acceptance rate lets lines sit long enough to absorb later writes, which separates a design that merges from one that only queues. The directed X/Y/Z sequence separates merge-into-oldest-line from strict arrival order. A repeated write to one word separates overwriting from keeping the first value. A write that collides with the line leaving in the same cycle separates allocating a fresh line from silently merging into a departing one. A fence issued with lines pending checks that intake is held back and that pre-fence lines leave first.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
  localparam int WB_ADDR_W     = 16;
  localparam int WB_DATA_W     = 32;
  localparam int WB_LINE_WORDS = 4;
  localparam int WB_ENTRIES    = 4;

  // What the input port does with the presented write in a cycle
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_MERGE = 2'd1,
    ACT_ALLOC = 2'd2,
    ACT_STALL = 2'd3
  } wr_act_e;
endpackage

// File: rtl/wbuf_line_store.sv
`timescale 1ns/1ps
module wbuf_line_store #(
  parameter  int ENTRIES    = 4,
  parameter  int TAG_W      = 14,
  parameter  int DATA_W     = 32,
  parameter  int LINE_WORDS = 4,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int SEL_W      = $clog2(LINE_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         wr_new,
  input  logic [IDX_W-1:0]             wr_slot,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         clr_en,
  input  logic [IDX_W-1:0]             clr_slot,
  input  logic [IDX_W-1:0]             rd_slot,
  output logic [ENTRIES-1:0]           valid_o,
  output logic [ENTRIES*TAG_W-1:0]     tags_o,
  output logic [TAG_W-1:0]             rd_tag_o,
  output logic [LINE_WORDS-1:0]        rd_mask_o,
  output logic [LINE_WORDS*DATA_W-1:0] rd_line_o
);
  localparam int DEPTH = ENTRIES * LINE_WORDS;

  // Word storage: single write port, no reset, flat index {slot, word}
  logic [DATA_W-1:0]     words_q [DEPTH];
  logic [TAG_W-1:0]      tag_q   [ENTRIES];
  logic [LINE_WORDS-1:0] mask_q  [ENTRIES];
  logic [ENTRIES-1:0]    valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) words_q[{wr_slot, wr_sel}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        mask_q[i] <= '0;
      end
    end else begin
      if (clr_en) valid_q[clr_slot] <= 1'b0;
      if (wr_en) begin
        if (wr_new) begin
          valid_q[wr_slot] <= 1'b1;
          tag_q[wr_slot]   <= wr_tag;
          mask_q[wr_slot]  <= LINE_WORDS'(1) << wr_sel;
        end else begin
          mask_q[wr_slot][wr_sel] <= 1'b1;
        end
      end
    end
  end

  assign valid_o   = valid_q;
  assign rd_tag_o  = tag_q[rd_slot];
  assign rd_mask_o = mask_q[rd_slot];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_tags
    assign tags_o[e*TAG_W +: TAG_W] = tag_q[e];
  end

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_rd
    assign rd_line_o[w*DATA_W +: DATA_W] = words_q[{rd_slot, SEL_W'(w)}];
  end

  // R2
  merge_target_live_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_new) |-> valid_q[wr_slot]);

  // R2
  word_marked_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mask_q[$past(wr_slot)][$past(wr_sel)]);

  // R6
  alloc_free_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_new) |-> !valid_q[wr_slot]);
endmodule

// File: rtl/wbuf_tag_match.sv
`timescale 1ns/1ps
module wbuf_tag_match #(
  parameter  int ENTRIES = 4,
  parameter  int TAG_W   = 14,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]       valid_i,
  input  logic [ENTRIES*TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]         key_i,
  input  logic                     skip_en_i,
  input  logic [IDX_W-1:0]         skip_slot_i,
  output logic [ENTRIES-1:0]       hit_vec_o,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         hit_slot_o,
  output logic                     free_o,
  output logic [IDX_W-1:0]         free_slot_o
);
  // One comparator per slot; the slot leaving this cycle is excluded
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec_o[e] = valid_i[e]
                        && (tags_i[e*TAG_W +: TAG_W] == key_i)
                        && !(skip_en_i && (skip_slot_i == IDX_W'(e)));
  end

  assign hit_o  = |hit_vec_o;
  assign free_o = ~&valid_i;

  always_comb begin
    hit_slot_o  = '0;
    free_slot_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec_o[i]) hit_slot_o  = IDX_W'(i);
      if (!valid_i[i])  free_slot_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wbuf_age_queue.sv
`timescale 1ns/1ps
module wbuf_age_queue #(
  parameter  int ENTRIES = 4,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] head_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [IDX_W-1:0] order_q [ENTRIES];
  logic [IDX_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) order_q[wr_ptr_q] <= push_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= bump(wr_ptr_q);
      if (pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = order_q[rd_ptr_q];
  assign empty_o = (count_q == '0);
  assign count_o = count_q;

  // R6
  no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (count_q < CNT_W'(ENTRIES)));

  // R4
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count_q != '0));
endmodule

// File: rtl/line_merge_wbuf.sv
`timescale 1ns/1ps
module line_merge_wbuf
  import wbuf_pkg::*;
#(
  parameter  int ADDR_W     = WB_ADDR_W,
  parameter  int DATA_W     = WB_DATA_W,
  parameter  int LINE_WORDS = WB_LINE_WORDS,
  parameter  int ENTRIES    = WB_ENTRIES,
  localparam int SEL_W      = $clog2(LINE_WORDS),
  localparam int TAG_W      = ADDR_W - SEL_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         fence,
  output logic                         wb_valid,
  input  logic                         wb_ready,
  output logic [TAG_W-1:0]             wb_line,
  output logic [LINE_WORDS*DATA_W-1:0] wb_data,
  output logic [LINE_WORDS-1:0]        wb_mask
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [TAG_W-1:0]         in_tag;
  logic [SEL_W-1:0]         in_sel;
  logic [ENTRIES-1:0]       valid_vec, hit_vec;
  logic [ENTRIES*TAG_W-1:0] tags;
  logic                     hit_any, free_any, drain, blocked, fence_q, q_empty;
  logic [IDX_W-1:0]         hit_slot, free_slot, head;
  logic [CNT_W-1:0]         q_count;
  logic                     st_wr_en, st_new;
  logic [IDX_W-1:0]         st_slot;
  wr_act_e                  act;

  assign in_tag = wr_addr[ADDR_W-1:SEL_W];
  assign in_sel = wr_addr[SEL_W-1:0];

  assign wb_valid = !q_empty;
  assign drain    = wb_valid && wb_ready;

  wbuf_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
    .valid_i     (valid_vec),
    .tags_i      (tags),
    .key_i       (in_tag),
    .skip_en_i   (drain),
    .skip_slot_i (head),
    .hit_vec_o   (hit_vec),
    .hit_o       (hit_any),
    .hit_slot_o  (hit_slot),
    .free_o      (free_any),
    .free_slot_o (free_slot)
  );

  // Intake control
  always_comb begin
    blocked  = fence || (fence_q && !q_empty);
    wr_ready = !blocked && (hit_any || free_any);
    if (!wr_valid)      act = ACT_NONE;
    else if (!wr_ready) act = ACT_STALL;
    else if (hit_any)   act = ACT_MERGE;
    else                act = ACT_ALLOC;
    st_wr_en = (act == ACT_MERGE) || (act == ACT_ALLOC);
    st_new   = (act == ACT_ALLOC);
    st_slot  = hit_any ? hit_slot : free_slot;
  end

  // Sticky fence: held until the buffer has emptied
  always_ff @(posedge clk) begin
    if (rst)          fence_q <= 1'b0;
    else if (fence)   fence_q <= 1'b1;
    else if (q_empty) fence_q <= 1'b0;
  end

  wbuf_line_store #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (st_wr_en),
    .wr_new    (st_new),
    .wr_slot   (st_slot),
    .wr_tag    (in_tag),
    .wr_sel    (in_sel),
    .wr_data   (wr_data),
    .clr_en    (drain),
    .clr_slot  (head),
    .rd_slot   (head),
    .valid_o   (valid_vec),
    .tags_o    (tags),
    .rd_tag_o  (wb_line),
    .rd_mask_o (wb_mask),
    .rd_line_o (wb_data)
  );

  wbuf_age_queue #(.ENTRIES(ENTRIES)) u_age (
    .clk      (clk),
    .rst      (rst),
    .push     (st_new),
    .push_idx (free_slot),
    .pop      (drain),
    .head_o   (head),
    .empty_o  (q_empty),
    .count_o  (q_count)
  );

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> (!wb_valid && (fence || wr_ready)));

  // R4
  hold_line_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_line)));

  // R6
  count_match_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(valid_vec) == int'(q_count));

  // R2
  single_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R8
  fence_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fence) && wb_valid) |-> !wr_ready);
endmodule

// File: tb/line_merge_wbuf_tb.sv
`timescale 1ns/1ps
module line_merge_wbuf_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         wr_valid, wr_ready, fence, wb_valid, wb_ready;
  logic [15:0]  wr_addr;
  logic [31:0]  wr_data;
  logic [13:0]  wb_line;
  logic [127:0] wb_data;
  logic [3:0]   wb_mask;

  always #2.5 clk = ~clk;

  line_merge_wbuf u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .fence(fence),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_line(wb_line),
    .wb_data(wb_data), .wb_mask(wb_mask)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model: held lines, oldest at index 0
  int          mn = 0;
  logic [13:0] mt [4];
  logic [3:0]  mm [4];
  logic [31:0] md [4][4];
  bit          fq = 0;
  // Log of lines taken by memory
  logic [13:0] dl_tag [64];
  logic [3:0]  dl_mask [64];
  int          dn = 0;
  // Last sampled outputs
  logic s_ready, s_valid;
  logic [13:0] s_line;
  logic [3:0]  s_mask;
  logic [127:0] s_data;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] masked(input logic [127:0] v, input logic [3:0] m);
    logic [127:0] r = '0;
    for (int k = 0; k < 4; k++) if (m[k]) r[k*32 +: 32] = v[k*32 +: 32];
    return r;
  endfunction

  task automatic step(input bit v, input logic [15:0] a, input logic [31:0] d,
                      input bit f, input bit mr);
    bit ev, dr, er, blk;
    int hit, n0;
    logic [127:0] eline;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; fence = f; wb_ready = mr;
    #1;
    n0  = mn;
    ev  = (mn > 0);
    dr  = ev && mr;
    hit = -1;
    for (int i = (dr ? 1 : 0); i < mn; i++) if (mt[i] == a[15:2]) hit = i;
    blk = f || (fq && mn > 0);
    er  = !blk && (hit >= 0 || mn < 4);
    s_ready = wr_ready; s_valid = wb_valid; s_line = wb_line;
    s_mask = wb_mask; s_data = wb_data;
    chk(wr_ready == er, "R6", "wr_ready", 128'(wr_ready), 128'(er));
    chk(wb_valid == ev, "R4", "wb_valid", 128'(wb_valid), 128'(ev));
    if (ev) begin
      eline = '0;
      for (int k = 0; k < 4; k++) eline[k*32 +: 32] = md[0][k];
      chk(wb_line == mt[0], "R4", "wb_line", 128'(wb_line), 128'(mt[0]));
      chk(wb_mask == mm[0], "R2", "wb_mask", 128'(wb_mask), 128'(mm[0]));
      chk(masked(wb_data, mm[0]) == masked(eline, mm[0]), "R3", "wb_data",
          masked(wb_data, mm[0]), masked(eline, mm[0]));
    end
    if (v && er && hit >= 0) begin
      md[hit][a[1:0]] = d;
      mm[hit][a[1:0]] = 1'b1;
    end
    if (dr) begin
      if (dn < 64) begin dl_tag[dn] = mt[0]; dl_mask[dn] = mm[0]; dn++; end
      for (int i = 0; i < 3; i++) begin
        mt[i] = mt[i+1]; mm[i] = mm[i+1];
        for (int k = 0; k < 4; k++) md[i][k] = md[i+1][k];
      end
      mn--;
    end
    if (v && er && hit < 0) begin
      mt[mn] = a[15:2]; mm[mn] = 4'b0001 << a[1:0]; md[mn][a[1:0]] = d;
      mn++;
    end
    if (f) fq = 1;
    else if (n0 == 0) fq = 0;
  endtask

  task automatic drain_all();
    for (int i = 0; i < 6; i++) step(0, '0, '0, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R4 watchdog: act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_0a17));
    rst = 1; wr_valid = 0; wr_addr = '0; wr_data = '0; fence = 0; wb_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: empty after reset
    step(0, '0, '0, 0, 0);
    chk(s_ready == 1'b1, "R1", "wr_ready after reset", 128'(s_ready), 128'(1));
    chk(s_valid == 1'b0, "R1", "wb_valid after reset", 128'(s_valid), 128'(0));

    // R5 / R2: X, Y, Z with X and Z sharing a line
    dn = 0;
    step(1, {14'h010, 2'd0}, 32'hAAAA_0001, 0, 0);
    step(1, {14'h020, 2'd1}, 32'hBBBB_0002, 0, 0);
    step(1, {14'h010, 2'd2}, 32'hCCCC_0003, 0, 0);
    step(0, '0, '0, 0, 0);
    chk(s_line == 14'h010, "R2", "merged line", 128'(s_line), 128'(14'h010));
    chk(s_mask == 4'b0101, "R2", "merged mask", 128'(s_mask), 128'(4'b0101));
    chk(s_data[95:64] == 32'hCCCC_0003 && s_data[31:0] == 32'hAAAA_0001, "R2",
        "merged words", s_data, 128'h0000_0000_CCCC_0003_0000_0000_AAAA_0001);
    drain_all();
    chk(dn == 2, "R5", "write-back count", 128'(dn), 128'(2));
    chk(dl_tag[0] == 14'h010 && dl_mask[0] == 4'b0101, "R5", "first write-back",
        128'({dl_tag[0], dl_mask[0]}), 128'({14'h010, 4'b0101}));
    chk(dl_tag[1] == 14'h020 && dl_mask[1] == 4'b0010, "R5", "second write-back",
        128'({dl_tag[1], dl_mask[1]}), 128'({14'h020, 4'b0010}));

    // R3 / R9: overwrite of a held word while memory stalls
    step(1, {14'h030, 2'd1}, 32'h1111_1111, 0, 0);
    step(0, '0, '0, 0, 0);
    chk(s_data[63:32] == 32'h1111_1111, "R9", "first word", 128'(s_data[63:32]), 128'(32'h1111_1111));
    step(1, {14'h030, 2'd1}, 32'h2222_2222, 0, 0);
    step(0, '0, '0, 0, 0);
    chk(s_data[63:32] == 32'h2222_2222, "R3", "overwritten word", 128'(s_data[63:32]), 128'(32'h2222_2222));
    chk(s_mask == 4'b0010, "R9", "mask after merge", 128'(s_mask), 128'(4'b0010));
    drain_all();

    // R6: full buffer stalls a miss but takes a hit
    for (int i = 0; i < 4; i++) step(1, {14'h040 + 14'(i), 2'd0}, 32'(i), 0, 0);
    step(1, {14'h044, 2'd0}, 32'h44, 0, 0);
    chk(s_ready == 1'b0, "R6", "miss when full", 128'(s_ready), 128'(0));
    step(1, {14'h042, 2'd3}, 32'h42, 0, 0);
    chk(s_ready == 1'b1, "R6", "hit when full", 128'(s_ready), 128'(1));
    drain_all();

    // R7: write to the leaving line opens a new line
    dn = 0;
    step(1, {14'h050, 2'd0}, 32'h5050_0000, 0, 0);
    step(1, {14'h050, 2'd3}, 32'h5050_0003, 0, 1);
    chk(s_ready == 1'b1, "R7", "accept during drain", 128'(s_ready), 128'(1));
    step(0, '0, '0, 0, 0);
    chk(s_valid && s_line == 14'h050 && s_mask == 4'b1000, "R7", "new line",
        128'({s_valid, s_line, s_mask}), 128'({1'b1, 14'h050, 4'b1000}));
    chk(dl_mask[0] == 4'b0001, "R7", "departed mask", 128'(dl_mask[0]), 128'(4'b0001));
    drain_all();

    // R8: fence holds intake until empty; pre-fence lines leave first
    dn = 0;
    step(1, {14'h060, 2'd0}, 32'h60, 0, 0);
    step(1, {14'h061, 2'd0}, 32'h61, 0, 0);
    step(1, {14'h062, 2'd0}, 32'h62, 1, 0);
    chk(s_ready == 1'b0, "R8", "fence cycle", 128'(s_ready), 128'(0));
    step(1, {14'h062, 2'd0}, 32'h62, 0, 0);
    chk(s_ready == 1'b0, "R8", "after fence", 128'(s_ready), 128'(0));
    for (int k = 0; k < 10; k++) begin
      step(1, {14'h062, 2'd0}, 32'h62, 0, 1);
      if (s_ready) break;
    end
    drain_all();
    chk(dn == 3 && dl_tag[0] == 14'h060 && dl_tag[1] == 14'h061 && dl_tag[2] == 14'h062,
        "R8", "order across fence", 128'({dl_tag[0], dl_tag[1], dl_tag[2]}),
        128'({14'h060, 14'h061, 14'h062}));

    // Random mix over six lines
    for (int c = 0; c < 4000; c++) begin
      step(($urandom % 4) != 0,
           {14'h100 + 14'($urandom % 6), 2'($urandom % 4)},
           $urandom, ($urandom % 64) == 0, ($urandom % 3) == 0);
    end
    drain_all();
    chk(s_valid == 1'b0, "R4", "empty at end", 128'(s_valid), 128'(0));

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule